// File: doc/BRIEF.md
# NMI-Aware Active Priority Tracker

This block keeps the active-priority state of one interrupt controller CPU interface. The state covers three interrupt groups: group 0, secure group 1 and non-secure group 1. Each group has a set of 32-bit words in which bit n stands for the preemption level n that is currently active. The two group-1 sets also have a single non-maskable (NMI) flag, held at bit 63 of their word 0.

The block takes three kinds of event. An activate event carries a priority, a group and an NMI flag. A drop event carries a group and removes that group's highest active level. Software reads and writes reach the words through a plain register port. From the stored state the block derives three outputs with no added latency:

- the highest active priority;
- the group that owns the highest active interrupt;
- the running-priority value, with the NMI status bits placed in its top two bits.

Configuration inputs control the derivation: NMI support, security disable, current security state and presence of the highest exception level. Pending-interrupt arbitration lies outside the block. The parameter `PRIO_BITS` sets the number of implemented priority bits, from 5 to 7. The number of words per group is 2^(PRIO_BITS-5). The priority shift is 8-PRIO_BITS.

Top module: `nmi_active_prio_tracker`

## Requirements
- R1: After reset all words and NMI flags are zero. The highest active priority reads 0xFF and the active group reads 3 (idle). The running-priority value is 0x00000000000000FF.
- R2: A non-NMI activation with priority p sets bit k mod 32 of word k div 32 in the selected group, where k = p >> (8-PRIO_BITS). The group codes are 0 = group 0, 1 = secure group 1, 2 = non-secure group 1 and 3 = none. The new bit is visible on the read port in the cycle after the event.
- R3: When NMI support is on, an NMI activation in group code 1 or 2 sets only bit 63 of that group's word 0. If NMI support is off, or the group is 0, the ordinary level bit is set instead.
- R4: A drop clears only the group's NMI flag if that flag is set. Otherwise it clears the lowest set bit of the lowest-numbered non-zero word of that group. The other groups are left unchanged.
- R5: Without an effective NMI flag, the highest active priority is (w*32 + b) << (8-PRIO_BITS). Here w is the lowest word that is non-zero in any group, and b is the lowest bit set in that word across the groups. The value is 0xFF when nothing is active.
- R6: When NMI support is on and the secure group-1 NMI flag is set, the highest active priority is 0. Otherwise, when the non-secure group-1 flag is set, it is 0 if security disable is on and 0x80 if it is off.
- R7: The active group is 1 when the secure NMI flag is effective, and 2 when the non-secure flag is effective. Otherwise it is the group holding the level from R5, with ties resolved in the order 0, then 1, then 2. It is 3 when nothing is active.
- R8: The running-priority value holds the highest active priority in bits 7:0, and bits 61:8 are zero. With NMI support on, the highest level present and the core non-secure, bit 63 equals the non-secure NMI flag and bit 62 is 0. With NMI support on in any other case, bit 63 equals the secure flag and bit 62 equals the non-secure flag. With NMI support off, bits 63 and 62 are 0.
- R9: A software write keeps bits 31:0. Bit 63 is kept only for word 0 of group 1 or 2 while NMI support is on. Every other bit reads back as zero.
- R10: An activate and a drop to the same group in the same cycle are applied in that order. The drop therefore sees the newly set bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_nmi_en | input | 1 | NMI support enabled |
| cfg_sec_disable | input | 1 | Security disabled |
| cfg_secure | input | 1 | Core in secure state |
| cfg_el3 | input | 1 | Highest exception level present |
| act_valid | input | 1 | Activate event |
| act_prio | input | 8 | Priority of activated interrupt |
| act_grp | input | 2 | Group of activated interrupt |
| act_nmi | input | 1 | Activated interrupt is non-maskable |
| drop_valid | input | 1 | Priority-drop event |
| drop_grp | input | 2 | Group whose highest level is dropped |
| wr_en | input | 1 | Software write strobe |
| wr_grp | input | 2 | Group written |
| wr_word | input | WIDX_W | Word index written |
| wr_data | input | 64 | Write data |
| rd_grp | input | 2 | Group read |
| rd_word | input | WIDX_W | Word index read |
| rd_data | output | 64 | Read data, NMI flag at bit 63 |
| hap | output | 8 | Highest active priority |
| hag | output | 2 | Group of highest active interrupt |
| rpr | output | 64 | Running-priority value |

## Verification
Every level in every group is activated on its own and then dropped. This ties each priority to the right bit position and proves that the low priority bits are ignored. A sweep over pairs of levels in all group pairs tells the lowest-level search apart from the group tie order. Walking through all 64 combinations of the two NMI flags and the four configuration inputs separates the NMI precedence from the ordinary scan and from the two bit layouts of the running-priority value. Multi-bit drops, masked writes and same-cycle activate-plus-drop cases check the clearing order and the event order.

// File: rtl/aprt_pkg.sv
package aprt_pkg;
    localparam int WORD_W = 32;

    typedef enum logic [1:0] {
        GRP_ZERO   = 2'd0,
        GRP_ONE_S  = 2'd1,
        GRP_ONE_NS = 2'd2,
        GRP_IDLE   = 2'd3
    } apr_grp_e;

    localparam logic [7:0] PRIO_IDLE   = 8'hFF;
    localparam logic [7:0] PRIO_NS_NMI = 8'h80;
endpackage

// File: rtl/aprt_group.sv
module aprt_group #(
    parameter int NUM_WORDS = 1,
    parameter int IDX_W     = 1,
    parameter bit HAS_NMI   = 1'b0
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          nmi_en,
    input  logic                          act_hit,
    input  logic                          act_nmi,
    input  logic [IDX_W-1:0]              act_word,
    input  logic [4:0]                    act_bit,
    input  logic                          drop_hit,
    input  logic                          wr_hit,
    input  logic [IDX_W-1:0]              wr_word,
    input  logic [63:0]                   wr_data,
    output logic [NUM_WORDS*32-1:0]       words_o,
    output logic                          nmi_o
);
    typedef struct packed {
        logic [NUM_WORDS-1:0][31:0] words;
        logic                       nmi;
    } grp_state_t;

    grp_state_t st_q, st_d;

    always_comb begin
        logic done;
        done = 1'b0;
        st_d = st_q;
        // software write lands first
        if (wr_hit) begin
            for (int w = 0; w < NUM_WORDS; w++) begin
                if (wr_word == IDX_W'(w)) begin
                    st_d.words[w] = wr_data[31:0];
                end
            end
            if (wr_word == '0) begin
                st_d.nmi = HAS_NMI && nmi_en && wr_data[63];
            end
        end
        // activation before drop (R10)
        if (act_hit) begin
            if (HAS_NMI && nmi_en && act_nmi) begin
                st_d.nmi = 1'b1;
            end else begin
                for (int w = 0; w < NUM_WORDS; w++) begin
                    if (act_word == IDX_W'(w)) begin
                        st_d.words[w][act_bit] = 1'b1;
                    end
                end
            end
        end
        if (drop_hit) begin
            if (HAS_NMI && st_d.nmi) begin
                st_d.nmi = 1'b0;
            end else begin
                for (int w = 0; w < NUM_WORDS; w++) begin
                    if (!done && st_d.words[w] != '0) begin
                        st_d.words[w] = st_d.words[w] & (st_d.words[w] - 32'd1);
                        done = 1'b1;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign words_o = st_q.words;
    assign nmi_o   = st_q.nmi;

    // R3: an NMI activation touches only the flag
    p_nmi_act_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (act_hit && act_nmi && nmi_en && HAS_NMI && !wr_hit && !drop_hit)
        |=> (nmi_o && $stable(words_o)));

    // R2: an ordinary activation leaves a level bit set
    p_act_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (act_hit && !(act_nmi && nmi_en && HAS_NMI) && !wr_hit && !drop_hit)
        |=> (words_o != '0));

    // R4: a set NMI flag is cleared alone
    p_drop_nmi_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_hit && nmi_o && !act_hit && !wr_hit)
        |=> (!nmi_o && $stable(words_o)));

    // R4: otherwise exactly one level bit goes away
    p_drop_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_hit && !nmi_o && !act_hit && !wr_hit && words_o != '0)
        |=> ($countones(words_o) == $countones($past(words_o)) - 1));

    // R9: without NMI support a word-0 write leaves the flag clear
    p_wr_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && wr_word == '0 && !nmi_en && !act_hit)
        |=> !nmi_o);
endmodule

// File: rtl/aprt_resolve.sv
module aprt_resolve
    import aprt_pkg::*;
#(
    parameter int NUM_WORDS = 1,
    parameter int SHIFT     = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NUM_WORDS*32-1:0] w0_i,
    input  logic [NUM_WORDS*32-1:0] w1s_i,
    input  logic [NUM_WORDS*32-1:0] w1ns_i,
    input  logic                    nmi_s_i,
    input  logic                    nmi_ns_i,
    input  logic                    nmi_en,
    input  logic                    sec_disable,
    input  logic                    secure,
    input  logic                    el3,
    output logic [7:0]              hap_o,
    output logic [1:0]              hag_o,
    output logic [63:0]             rpr_o
);
    logic [7:0] scan_prio;
    apr_grp_e   scan_grp;
    apr_grp_e   top_grp;

    // ordinary scan: lowest word, then lowest bit
    always_comb begin
        logic        hit;
        int          pos;
        logic [31:0] u;
        hit       = 1'b0;
        pos       = 0;
        u         = '0;
        scan_prio = PRIO_IDLE;
        scan_grp  = GRP_IDLE;
        for (int w = 0; w < NUM_WORDS; w++) begin
            u = w0_i[w*32 +: 32] | w1s_i[w*32 +: 32] | w1ns_i[w*32 +: 32];
            if (!hit && u != '0) begin
                hit = 1'b1;
                for (int b = 31; b >= 0; b--) begin
                    if (u[b]) pos = b;
                end
                scan_prio = 8'((w*32 + pos) << SHIFT);
                if (w0_i[w*32 + pos])       scan_grp = GRP_ZERO;
                else if (w1s_i[w*32 + pos]) scan_grp = GRP_ONE_S;
                else                        scan_grp = GRP_ONE_NS;
            end
        end
    end

    // NMI flags override the scan
    always_comb begin
        if (nmi_en && nmi_s_i) begin
            hap_o   = 8'h00;
            top_grp = GRP_ONE_S;
        end else if (nmi_en && nmi_ns_i) begin
            hap_o   = sec_disable ? 8'h00 : PRIO_NS_NMI;
            top_grp = GRP_ONE_NS;
        end else begin
            hap_o   = scan_prio;
            top_grp = scan_grp;
        end
    end

    assign hag_o = top_grp;

    always_comb begin
        rpr_o      = '0;
        rpr_o[7:0] = hap_o;
        if (nmi_en) begin
            if (el3 && !secure) begin
                rpr_o[63] = nmi_ns_i;
            end else begin
                rpr_o[63] = nmi_s_i;
                rpr_o[62] = nmi_ns_i;
            end
        end
    end

    // R5: idle group always pairs with the idle priority
    p_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (hag_o == GRP_IDLE) |-> (hap_o == PRIO_IDLE));
endmodule

// File: rtl/nmi_active_prio_tracker.sv
module nmi_active_prio_tracker
    import aprt_pkg::*;
#(
    parameter int PRIO_BITS = 5,
    localparam int NUM_WORDS = 1 << (PRIO_BITS - 5),
    localparam int WIDX_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_nmi_en,
    input  logic              cfg_sec_disable,
    input  logic              cfg_secure,
    input  logic              cfg_el3,
    input  logic              act_valid,
    input  logic [7:0]        act_prio,
    input  logic [1:0]        act_grp,
    input  logic              act_nmi,
    input  logic              drop_valid,
    input  logic [1:0]        drop_grp,
    input  logic              wr_en,
    input  logic [1:0]        wr_grp,
    input  logic [WIDX_W-1:0] wr_word,
    input  logic [63:0]       wr_data,
    input  logic [1:0]        rd_grp,
    input  logic [WIDX_W-1:0] rd_word,
    output logic [63:0]       rd_data,
    output logic [7:0]        hap,
    output logic [1:0]        hag,
    output logic [63:0]       rpr
);
    localparam int SHIFT = 8 - PRIO_BITS;
    localparam int GW    = NUM_WORDS * WORD_W;

    logic [7:0]        act_lvl;
    logic [WIDX_W-1:0] act_word;
    logic [4:0]        act_bit;

    assign act_lvl  = act_prio >> SHIFT;
    assign act_bit  = act_lvl[4:0];
    assign act_word = WIDX_W'(act_lvl >> 5);

    logic [2:0][GW-1:0] grp_words;
    logic [2:0]         grp_nmi;

    for (genvar g = 0; g < 3; g++) begin : g_grp
        aprt_group #(
            .NUM_WORDS (NUM_WORDS),
            .IDX_W     (WIDX_W),
            .HAS_NMI   (g != 0)
        ) i_grp (
            .clk      (clk),
            .rst_n    (rst_n),
            .nmi_en   (cfg_nmi_en),
            .act_hit  (act_valid && act_grp == 2'(g)),
            .act_nmi  (act_nmi),
            .act_word (act_word),
            .act_bit  (act_bit),
            .drop_hit (drop_valid && drop_grp == 2'(g)),
            .wr_hit   (wr_en && wr_grp == 2'(g)),
            .wr_word  (wr_word),
            .wr_data  (wr_data),
            .words_o  (grp_words[g]),
            .nmi_o    (grp_nmi[g])
        );
    end

    always_comb begin
        rd_data = '0;
        for (int g = 0; g < 3; g++) begin
            for (int w = 0; w < NUM_WORDS; w++) begin
                if (rd_grp == 2'(g) && rd_word == WIDX_W'(w)) begin
                    rd_data[31:0] = grp_words[g][w*32 +: 32];
                    if (w == 0) rd_data[63] = grp_nmi[g];
                end
            end
        end
    end

    aprt_resolve #(
        .NUM_WORDS (NUM_WORDS),
        .SHIFT     (SHIFT)
    ) i_resolve (
        .clk         (clk),
        .rst_n       (rst_n),
        .w0_i        (grp_words[0]),
        .w1s_i       (grp_words[1]),
        .w1ns_i      (grp_words[2]),
        .nmi_s_i     (grp_nmi[1]),
        .nmi_ns_i    (grp_nmi[2]),
        .nmi_en      (cfg_nmi_en),
        .sec_disable (cfg_sec_disable),
        .secure      (cfg_secure),
        .el3         (cfg_el3),
        .hap_o       (hap),
        .hag_o       (hag),
        .rpr_o       (rpr)
    );

    // R1: group 0 never holds an NMI flag
    p_g0_no_nmi_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !grp_nmi[0]);

    // R8: middle bits of the running priority stay clear
    p_rpr_mid_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rpr[61:8] == '0) && (rpr[7:0] == hap));
endmodule

// File: tb/test_nmi_active_prio_tracker.sv
`timescale 1ns/100ps
module test_nmi_active_prio_tracker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_nmi_en = 1'b0, cfg_sec_disable = 1'b0, cfg_secure = 1'b0, cfg_el3 = 1'b0;
    logic        act_valid = 1'b0, act_nmi = 1'b0;
    logic [7:0]  act_prio = '0;
    logic [1:0]  act_grp = '0;
    logic        drop_valid = 1'b0;
    logic [1:0]  drop_grp = '0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_grp = '0;
    logic [0:0]  wr_word = '0;
    logic [63:0] wr_data = '0;
    logic [1:0]  rd_grp = '0;
    logic [0:0]  rd_word = '0;
    logic [63:0] rd_data, rpr;
    logic [7:0]  hap;
    logic [1:0]  hag;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    nmi_active_prio_tracker #(.PRIO_BITS(5)) i_nmi_active_prio_tracker (
        .clk(clk), .rst_n(rst_n), .cfg_nmi_en(cfg_nmi_en), .cfg_sec_disable(cfg_sec_disable),
        .cfg_secure(cfg_secure), .cfg_el3(cfg_el3), .act_valid(act_valid), .act_prio(act_prio),
        .act_grp(act_grp), .act_nmi(act_nmi), .drop_valid(drop_valid), .drop_grp(drop_grp),
        .wr_en(wr_en), .wr_grp(wr_grp), .wr_word(wr_word), .wr_data(wr_data),
        .rd_grp(rd_grp), .rd_word(rd_word), .rd_data(rd_data), .hap(hap), .hag(hag), .rpr(rpr)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] g, output logic [63:0] v);
        rd_grp = g;
        rd_word = '0;
        #0.5;
        v = rd_data;
    endtask

    task automatic act(input logic [7:0] p, input logic [1:0] g, input logic n);
        act_valid = 1'b1; act_prio = p; act_grp = g; act_nmi = n;
        @(negedge clk);
        act_valid = 1'b0; act_nmi = 1'b0;
    endtask

    task automatic drop(input logic [1:0] g);
        drop_valid = 1'b1; drop_grp = g;
        @(negedge clk);
        drop_valid = 1'b0;
    endtask

    task automatic wr(input logic [1:0] g, input logic [63:0] d);
        wr_en = 1'b1; wr_grp = g; wr_word = '0; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic clear_all();
        for (int g = 0; g < 3; g++) wr(2'(g), 64'd0);
    endtask

    function automatic logic [7:0] umin(input int a, input int b);
        return 8'((a < b) ? a : b);
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [63:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 hap", 64'(hap), 64'hFF);
        chk("R1 hag", 64'(hag), 64'd3);
        chk("R1 rpr", rpr, 64'hFF);
        for (int g = 0; g < 3; g++) begin
            rd(2'(g), v);
            chk("R1 word", v, 64'd0);
        end

        // single level sweep: R2, R5, R7, R4
        for (int g = 0; g < 3; g++) begin
            for (int i = 0; i < 32; i++) begin
                act(8'(i*8 + (i % 8)), 2'(g), 1'b0);
                rd(2'(g), v);
                chk("R2 level bit", v, 64'd1 << i);
                chk("R5 hap single", 64'(hap), 64'(i*8));
                chk("R7 hag single", 64'(hag), 64'(g));
                drop(2'(g));
                rd(2'(g), v);
                chk("R4 drop single", v, 64'd0);
                chk("R5 hap idle", 64'(hap), 64'hFF);
            end
        end

        // pair sweep: R5 lowest level, R7 tie order
        for (int ga = 0; ga < 3; ga++) begin
            for (int gb = 0; gb < 3; gb++) begin
                for (int i = 0; i < 32; i += 5) begin
                    for (int j = 0; j < 32; j += 5) begin
                        logic [1:0] eg;
                        clear_all();
                        act(8'(i*8), 2'(ga), 1'b0);
                        act(8'(j*8), 2'(gb), 1'b0);
                        if (i < j) eg = 2'(ga);
                        else if (j < i) eg = 2'(gb);
                        else eg = 2'((ga < gb) ? ga : gb);
                        chk("R5 hap pair", 64'(hap), 64'(umin(i, j) * 8));
                        chk("R7 hag pair", 64'(hag), 64'(eg));
                    end
                end
            end
        end

        // NMI precedence and running priority: R3, R6, R7, R8
        for (int c = 0; c < 64; c++) begin
            logic s, ns, ds, sec, e3, en;
            logic [7:0] eh;
            logic [1:0] eg;
            logic [63:0] er;
            {s, ns, ds, sec, e3, en} = 6'(c);
            cfg_nmi_en = 1'b1; cfg_sec_disable = 1'b0; cfg_secure = 1'b0; cfg_el3 = 1'b0;
            clear_all();
            act(8'd40, 2'd0, 1'b0);
            if (s)  act(8'h40, 2'd1, 1'b1);
            if (ns) act(8'h40, 2'd2, 1'b1);
            rd(2'd1, v);
            chk("R3 nmi only s", v, {s, 63'd0});
            rd(2'd2, v);
            chk("R3 nmi only ns", v, {ns, 63'd0});
            cfg_nmi_en = en; cfg_sec_disable = ds; cfg_secure = sec; cfg_el3 = e3;
            #0.5;
            if (en && s)       begin eh = 8'h00; eg = 2'd1; end
            else if (en && ns) begin eh = ds ? 8'h00 : 8'h80; eg = 2'd2; end
            else               begin eh = 8'd40; eg = 2'd0; end
            er = 64'(eh);
            if (en) begin
                if (e3 && !sec) er[63] = ns;
                else begin er[63] = s; er[62] = ns; end
            end
            chk("R6 hap nmi", 64'(hap), 64'(eh));
            chk("R7 hag nmi", 64'(hag), 64'(eg));
            chk("R8 rpr", rpr, er);
        end
        cfg_nmi_en = 1'b0; cfg_sec_disable = 1'b0; cfg_secure = 1'b0; cfg_el3 = 1'b0;

        // R3 fallbacks to ordinary bit
        clear_all();
        act(8'd24, 2'd1, 1'b1);
        rd(2'd1, v);
        chk("R3 nmi off gives level", v, 64'd1 << 3);
        cfg_nmi_en = 1'b1;
        act(8'd16, 2'd0, 1'b1);
        rd(2'd0, v);
        chk("R3 group0 nmi gives level", v, 64'd1 << 2);

        // R9 write masking
        for (int g = 0; g < 3; g++) begin
            for (int e = 0; e < 2; e++) begin
                cfg_nmi_en = e[0];
                wr(2'(g), 64'hFFFF_FFFF_FFFF_FFFF);
                rd(2'(g), v);
                chk("R9 write mask", v, {(g != 0) && (e != 0), 31'd0, 32'hFFFF_FFFF});
            end
        end

        // R4 drop order
        cfg_nmi_en = 1'b1;
        clear_all();
        wr(2'd0, 64'h2);
        wr(2'd1, 64'h8000_0000_0000_0088);
        drop(2'd1);
        rd(2'd1, v);
        chk("R4 nmi cleared first", v, 64'h88);
        drop(2'd1);
        rd(2'd1, v);
        chk("R4 lowest bit cleared", v, 64'h80);
        drop(2'd1);
        rd(2'd1, v);
        chk("R4 last bit cleared", v, 64'h0);
        rd(2'd0, v);
        chk("R4 other group untouched", v, 64'h2);

        // R10 activate before drop
        clear_all();
        act_valid = 1'b1; act_prio = 8'd32; act_grp = 2'd0; act_nmi = 1'b0;
        drop_valid = 1'b1; drop_grp = 2'd0;
        @(negedge clk);
        act_valid = 1'b0; drop_valid = 1'b0;
        rd(2'd0, v);
        chk("R10 empty act+drop", v, 64'd0);
        wr(2'd0, 64'h4);
        act_valid = 1'b1; act_prio = 8'd32; act_grp = 2'd0;
        drop_valid = 1'b1; drop_grp = 2'd0;
        @(negedge clk);
        act_valid = 1'b0; drop_valid = 1'b0;
        rd(2'd0, v);
        chk("R10 drop sees lower level", v, 64'h10);
        act_valid = 1'b1; act_prio = 8'd8; act_grp = 2'd2; act_nmi = 1'b1;
        drop_valid = 1'b1; drop_grp = 2'd2;
        @(negedge clk);
        act_valid = 1'b0; drop_valid = 1'b0; act_nmi = 1'b0;
        rd(2'd2, v);
        chk("R10 nmi act+drop", v, 64'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule